// File: doc/BRIEF.md
# I2C Bit-Rate Strobe Generator

This block divides a fast core clock down to the bit rate of an I2C master. It produces a one-cycle quarter-bit strobe, a 2-bit index of the current quarter, and a bit-boundary strobe. The byte controller uses these to place SCL edges and data sample points. The bit rate comes from a product rather than from one long counter. A power-of-two prescaler, set by a 3-bit exponent field, feeds a span counter. The span counter's length is the product of a 4-bit mantissa field plus one, a fixed base of five quarter units (twenty per bit), and a synthesis-time high-phase factor.

Software writes the divider value through a narrow select port. Only the clock-control select code with the read-select bit clear reaches the divider register; other codes belong to neighbouring registers and are ignored here. A new value waits in a pending register and moves to the active divider at the end of the bit in progress, so a running bit is never shortened or stretched. While the enable is low, the counters stay at zero, no strobes are produced, and the active divider follows the pending value. Enabling the block therefore always starts with the latest setting.

Top module: `i2c_clkgen`

## Requirements
- R1: While rst_ni is low, qtr_stb_o and bit_stb_o are 0 and qtr_phase_o is 0.
- R2: With the block enabled and a steady setting, qtr_stb_o pulses for exactly one core cycle every Q cycles, where Q = 5 × (M+1) × (THP+1) × 2^N. A full bit is therefore 20 × (M+1) × (THP+1) × 2^N cycles.
- R3: qtr_phase_o steps 0,1,2,3,0 and advances on the clock edge that follows each quarter strobe. bit_stb_o is high exactly when qtr_stb_o is high and qtr_phase_o is 3.
- R4: A write is taken only when cfg_we_i is 1, cfg_sel_i is 3 and cfg_rsel_i is 0. In that write, M is cfg_wdata_i[6:3] and N is cfg_wdata_i[2:0]. Writes with any other select code, or with cfg_rsel_i at 1, leave the strobe timing unchanged.
- R5: A value written while enabled takes effect from the bit that follows the next bit strobe. The quarters still left in the current bit keep the old period. A write taken in the very cycle of a bit strobe applies to the next bit.
- R6: While en_i is 0, no strobe is produced and qtr_phase_o returns to 0. A value written while disabled is the one in force when the block is enabled again.
- R7: After en_i rises, the first quarter strobe is high in the Q-th cycle in which en_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low holds the counters at zero |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 3 | Internal register select code (3 = clock control) |
| cfg_rsel_i | input | 1 | Read-select bit; must be 0 to reach clock control |
| cfg_wdata_i | input | 7 | Write data: M in [6:3], N in [2:0] |
| qtr_stb_o | output | 1 | One-cycle strobe at each quarter-bit end |
| bit_stb_o | output | 1 | One-cycle strobe at each bit end |
| qtr_phase_o | output | 2 | Index of the current quarter within the bit |

## Verification
The bench builds the block with THP = 1, so each quarter lasts 10 × (M+1) × 2^N cycles. At that size the largest exponent (N = 7, a 1280-cycle quarter) and the largest mantissa (M = 15) both fit into full measured bits. A behavioural model with a single cycle counter predicts every strobe and phase value each cycle. Directed period measurements cover the first strobe after enable, values written mid-bit, writes to foreign select codes, and disabled stretches.

// File: rtl/i2c_clkgen_pkg.sv
package i2c_clkgen_pkg;
  localparam int MANT_W   = 4;
  localparam int EXP_W    = 3;
  localparam int SEL_W    = 3;
  localparam int PHASE_W  = 2;
  localparam int CFG_W    = MANT_W + EXP_W;
  localparam int QTR_BASE = 5;  // 20 base units per bit, split in 4 quarters
  localparam logic [SEL_W-1:0] SEL_CLKCTL = SEL_W'(3);

  typedef struct packed {
    logic [MANT_W-1:0] mant;
    logic [EXP_W-1:0]  expo;
  } clk_cfg_t;

  function automatic clk_cfg_t decode_cfg(input logic [CFG_W-1:0] d);
    clk_cfg_t c;
    c.mant = d[CFG_W-1:EXP_W];
    c.expo = d[EXP_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/i2c_clkgen_cfg.sv
module i2c_clkgen_cfg
  import i2c_clkgen_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             bit_bound_i,
  input  logic             we_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             rsel_i,
  input  logic [CFG_W-1:0] wdata_i,
  output clk_cfg_t         active_o
);
  logic     wr_hit;
  clk_cfg_t pend_q, pend_d, act_q;

  assign wr_hit = we_i && (sel_i == SEL_CLKCTL) && !rsel_i;
  // forward a write landing on the boundary cycle straight to the next bit
  assign pend_d = wr_hit ? decode_cfg(wdata_i) : pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_d;
      if (!en_i || bit_bound_i) act_q <= pend_d;
    end
  end

  assign active_o = act_q;

  p_foreign_write_ignored_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit |=> pend_q == $past(pend_q));

  p_active_held_mid_bit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !bit_bound_i) |=> act_q == $past(act_q));
endmodule

// File: rtl/i2c_clkgen_pow2.sv
module i2c_clkgen_pow2 #(
  parameter int EXP_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [EXP_W-1:0] expo_i,
  output logic             tick_o
);
  localparam int CNT_W = (1 << EXP_W) - 1;

  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] lim, cnt_q;

  always_comb begin
    span = {{CNT_W{1'b0}}, 1'b1} << expo_i;
    lim  = CNT_W'(span - 1'b1);
  end

  assign tick_o = en_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  p_prescale_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> cnt_q <= lim);
endmodule

// File: rtl/i2c_clkgen_qtr.sv
module i2c_clkgen_qtr #(
  parameter int MANT_W   = 4,
  parameter int THP      = 2,
  parameter int QTR_BASE = 5,
  parameter int PHASE_W  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               tick_i,
  input  logic [MANT_W-1:0]  mant_i,
  output logic               qtr_o,
  output logic               bit_o,
  output logic [PHASE_W-1:0] phase_o
);
  localparam int UNIT     = QTR_BASE * (THP + 1);
  localparam int SPAN_MAX = UNIT * (1 << MANT_W);
  localparam int CNT_W    = $clog2(SPAN_MAX);

  logic [CNT_W-1:0]   cnt_q, last;
  logic [PHASE_W-1:0] phase_q;

  always_comb last = CNT_W'((32'(mant_i) + 32'd1) * 32'(UNIT) - 32'd1);

  assign qtr_o   = tick_i && (cnt_q == last);
  assign bit_o   = qtr_o && (&phase_q);
  assign phase_o = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= '0;
    end else if (!en_i) begin
      cnt_q   <= '0;
      phase_q <= '0;
    end else if (qtr_o) begin
      cnt_q   <= '0;
      phase_q <= phase_q + 1'b1;
    end else if (tick_i) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  p_strobe_one_wide_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qtr_o |=> !qtr_o);

  p_phase_steps_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && qtr_o) |=> phase_q == PHASE_W'($past(phase_q) + 1'b1));

  p_phase_holds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !qtr_o) |=> $stable(phase_q));
endmodule

// File: rtl/i2c_clkgen.sv
module i2c_clkgen
  import i2c_clkgen_pkg::*;
#(
  parameter int THP = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               cfg_we_i,
  input  logic [SEL_W-1:0]   cfg_sel_i,
  input  logic               cfg_rsel_i,
  input  logic [CFG_W-1:0]   cfg_wdata_i,
  output logic               qtr_stb_o,
  output logic               bit_stb_o,
  output logic [PHASE_W-1:0] qtr_phase_o
);
  clk_cfg_t act;
  logic     pre_tick;

  i2c_clkgen_cfg u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .bit_bound_i (bit_stb_o),
    .we_i        (cfg_we_i),
    .sel_i       (cfg_sel_i),
    .rsel_i      (cfg_rsel_i),
    .wdata_i     (cfg_wdata_i),
    .active_o    (act)
  );

  i2c_clkgen_pow2 #(.EXP_W(EXP_W)) u_pow2 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .expo_i (act.expo),
    .tick_o (pre_tick)
  );

  i2c_clkgen_qtr #(
    .MANT_W   (MANT_W),
    .THP      (THP),
    .QTR_BASE (QTR_BASE),
    .PHASE_W  (PHASE_W)
  ) u_qtr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .tick_i  (pre_tick),
    .mant_i  (act.mant),
    .qtr_o   (qtr_stb_o),
    .bit_o   (bit_stb_o),
    .phase_o (qtr_phase_o)
  );

  p_bit_on_last_quarter_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_stb_o |-> (qtr_stb_o && qtr_phase_o == PHASE_W'(3)));

  p_idle_when_disabled_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (qtr_phase_o == '0));
endmodule

// File: tb/i2c_clkgen_tb_top.sv
module i2c_clkgen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TB_THP     = 1;
  localparam int WD_LIMIT   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, we = 1'b0, rsel = 1'b0;
  logic [2:0] sel = 3'd0;
  logic [6:0] wdata = 7'd0;
  logic       qtr_stb, bit_stb;
  logic [1:0] phase;

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_clkgen #(.THP(TB_THP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .cfg_we_i(we), .cfg_sel_i(sel),
    .cfg_rsel_i(rsel), .cfg_wdata_i(wdata), .qtr_stb_o(qtr_stb),
    .bit_stb_o(bit_stb), .qtr_phase_o(phase)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural model: one cycle counter per quarter
  int m_cnt = 0, m_phase = 0, act_m = 0, act_n = 0, pend_m = 0, pend_n = 0;

  function automatic int qlen(input int m, input int n);
    return 5 * (m + 1) * (TB_THP + 1) * (1 << n);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_phase = 0; act_m = 0; act_n = 0; pend_m = 0; pend_n = 0;
    end else begin
      bit hit, stb, bnd;
      int nm, nn;
      hit = we && sel == 3'd3 && !rsel;
      nm  = hit ? int'(wdata[6:3]) : pend_m;
      nn  = hit ? int'(wdata[2:0]) : pend_n;
      stb = en && (m_cnt == qlen(act_m, act_n) - 1);
      bnd = stb && m_phase == 3;
      if (!en) begin m_cnt = 0; m_phase = 0; end
      else if (stb) begin m_cnt = 0; m_phase = (m_phase + 1) % 4; end
      else m_cnt++;
      if (!en || bnd) begin act_m = nm; act_n = nn; end
      pend_m = nm; pend_n = nn;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int e_q, e_b;
      e_q = (en && m_cnt == qlen(act_m, act_n) - 1) ? 1 : 0;
      e_b = (e_q == 1 && m_phase == 3) ? 1 : 0;
      chk(en ? "R2" : "R6", "model qtr_stb", int'(qtr_stb), e_q);
      chk("R3", "model bit_stb", int'(bit_stb), e_b);
      chk("R3", "model phase", int'(phase), m_phase);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == WD_LIMIT && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WD_LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wr_cfg(input logic [2:0] s, input logic r, input logic [6:0] d);
    @(posedge clk); #1;
    we = 1'b1; sel = s; rsel = r; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic set_en(input logic v);
    @(posedge clk); #1;
    en = v;
  endtask

  // counts negedges up to and including the next quarter strobe
  task automatic wait_qtr(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!qtr_stb && n < 30000);
  endtask

  task automatic next_bit();
    int n;
    do wait_qtr(n); while (!bit_stb && n < 30000);
  endtask

  initial begin
    int n, sum;
    repeat (3) @(negedge clk);
    chk("R1", "qtr_stb in reset", int'(qtr_stb), 0);
    chk("R1", "bit_stb in reset", int'(bit_stb), 0);
    chk("R1", "phase in reset", int'(phase), 0);
    @(posedge clk); #1; rst_n = 1'b1;

    // R6 / R7: value written while disabled, first strobe after enable
    wr_cfg(3'd3, 1'b0, 7'h08);               // M=1 N=0 -> Q=20
    set_en(1'b1);
    wait_qtr(n); chk("R7", "first strobe delay", n, 20);
    wait_qtr(n); chk("R2", "quarter period M1 N0", n, 20);
    chk("R3", "phase on 2nd strobe", int'(phase), 1);

    next_bit();
    chk("R3", "phase at bit strobe", int'(phase), 3);

    // R5: mid-bit write keeps the running bit
    wr_cfg(3'd3, 1'b0, 7'h02);               // M=0 N=2 -> Q=40
    wait_qtr(n);
    wait_qtr(n); chk("R5", "old period q1", n, 20);
    wait_qtr(n); chk("R5", "old period q2", n, 20);
    wait_qtr(n); chk("R5", "old period q3", n, 20);
    chk("R3", "bit strobe after q3", int'(bit_stb), 1);
    wait_qtr(n); chk("R5", "new period next bit", n, 40);

    // R4: foreign selects ignored
    wr_cfg(3'd3, 1'b1, 7'h7F);
    wr_cfg(3'd2, 1'b0, 7'h7F);
    next_bit();
    wait_qtr(n); chk("R4", "period after ignored writes", n, 40);

    wr_cfg(3'd3, 1'b0, 7'h78);               // M=15 N=0 -> Q=160
    next_bit();
    wait_qtr(n); chk("R2", "quarter period M15 N0", n, 160);

    wr_cfg(3'd3, 1'b0, 7'h07);               // M=0 N=7 -> Q=1280
    next_bit();
    sum = 0;
    for (int q = 0; q < 4; q++) begin
      wait_qtr(n);
      sum += n;
      chk("R2", "quarter period M0 N7", n, 1280);
    end
    chk("R2", "bit period M0 N7", sum, 5120);
    chk("R3", "bit strobe on 4th quarter", int'(bit_stb), 1);

    // R6: disabled stretch
    set_en(1'b0);
    sum = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      sum += int'(qtr_stb) + int'(bit_stb);
    end
    chk("R6", "strobes while disabled", sum, 0);
    chk("R6", "phase while disabled", int'(phase), 0);
    wr_cfg(3'd3, 1'b0, 7'h01);               // M=0 N=1 -> Q=20
    set_en(1'b1);
    wait_qtr(n); chk("R7", "first strobe after re-enable", n, 20);
    wait_qtr(n); chk("R2", "quarter period M0 N1", n, 20);

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule